// File: doc/BRIEF.md
# Acquisition Start Trigger Controller

This block decides when the sample sequencer of an analog acquisition path may convert. Software writes a trigger configuration and then raises an arm level. The controller turns that setting and the state of an external trigger into a single run level. In software mode, run follows the arm level. In hardware mode, run waits for a condition on either a digital trigger pin or an analog trigger. The analog trigger reaches the block as two comparator flags, one for each threshold.

Two trigger types exist. In edge type, the first qualifying transition seen while armed turns run on, and run stays on until the block is de-armed. In level type, run is allowed only while the trigger sits at the chosen level, so conversion pauses and resumes with it. The analog path adds hysteresis: its state becomes high only when the signal rises above the upper threshold, and low only when it falls below the lower one. All trigger inputs are asynchronous and are synchronized inside the block.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, run_o is 0.
- R2: With hw_mode_i = 0 (software trigger), run_o is 1 on the first clock edge at which arm_i is sampled high, whatever the trigger inputs do.
- R3: In hardware edge type (lvl_type_i = 0), dir_i selects the edge that qualifies: 00 = falling, 01 = rising, 10 or 11 = either. A transition of the other polarity leaves run_o at 0. The qualifying transition sets run_o.
- R4: Once an edge has set run_o, later trigger changes leave run_o at 1 for as long as arm_i stays high.
- R5: A trigger transition completed while arm_i is low does not start acquisition after arming.
- R6: In hardware level type (lvl_type_i = 1) with dir_i = 01, run_o is 1 only while the trigger is high. With dir_i = 00, run_o is 1 only while the trigger is low. run_o follows the trigger back and forth.
- R7: In level type with dir_i = 10 or 11, run_o behaves as in software mode.
- R8: With src_ana_i = 1, the analog trigger state becomes 1 when cmp_hi_i is set and cmp_lo_i is clear. It becomes 0 when cmp_lo_i is set and cmp_hi_i is clear. It holds its value when neither flag, or both flags, are set.
- R9: Latency: a digital trigger change reaches run_o on the third rising clock edge after it. An analog comparator change reaches run_o on the fourth.
- R10: When arm_i is sampled low, run_o is 0 after that clock edge and the edge latch is cleared. Re-arming then needs a new qualifying edge.
- R11: The trigger source that src_ana_i does not select has no effect on run_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm level; low clears the edge latch and stops acquisition |
| hw_mode_i | input | 1 | 0 = software trigger, 1 = hardware trigger |
| src_ana_i | input | 1 | 0 = digital trigger pin, 1 = analog comparator pair |
| lvl_type_i | input | 1 | 0 = edge type, 1 = level type |
| dir_i | input | 2 | 00 falling/low, 01 rising/high, 1x either |
| dig_trig_i | input | 1 | Asynchronous digital trigger |
| cmp_hi_i | input | 1 | Asynchronous flag: analog input above the upper threshold |
| cmp_lo_i | input | 1 | Asynchronous flag: analog input below the lower threshold |
| run_o | output | 1 | Conversion allowed for the sample sequencer |

## Verification
Edge type is tried with transitions of the right polarity, the wrong polarity, and "either". A transition completed before arming is included, which separates a true edge detector from one that merely samples the level at arm time. Level type is toggled several times in both polarities to show pause and resume, and is also tried with "either" to compare it with software mode. The analog source is moved through the band between the thresholds from each side, which separates hysteresis from a single comparator. Exact-cycle checks on the digital and analog paths pin the synchronizer depth, and the unselected source is toggled to show it is isolated.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  typedef enum logic [1:0] {
    DIR_FALL  = 2'b00,
    DIR_RISE  = 2'b01,
    DIR_ANY_A = 2'b10,
    DIR_ANY_B = 2'b11
  } trig_dir_e;

  // Transition from prv to cur qualifies for the selected polarity
  function automatic logic edge_qualifies(trig_dir_e dir, logic prv, logic cur);
    logic q;
    case (dir)
      DIR_FALL: q = prv & ~cur;
      DIR_RISE: q = ~prv & cur;
      default:  q = prv ^ cur;
    endcase
    return q;
  endfunction

  // Current trigger value is at the selected level
  function automatic logic level_qualifies(trig_dir_e dir, logic cur);
    logic q;
    case (dir)
      DIR_FALL: q = ~cur;
      DIR_RISE: q = cur;
      default:  q = 1'b1;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[LAST];
endmodule

// File: rtl/acq_hyst.sv
module acq_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic state_o
);
  logic state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       state_q <= 1'b0;
    else if (above_hi_i && !below_lo_i) state_q <= 1'b1;
    else if (below_lo_i && !above_hi_i) state_q <= 1'b0;
  end

  assign state_o = state_q;

  // R8: set, clear and hold of the hysteresis state
  p_hyst_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi_i && !below_lo_i) |=> state_o);
  p_hyst_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (below_lo_i && !above_hi_i) |=> !state_o);
  p_hyst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi_i == below_lo_i) |=> $stable(state_o));
endmodule

// File: rtl/acq_trig_qual.sv
module acq_trig_qual
  import acq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       hw_mode_i,
  input  logic       lvl_type_i,
  input  logic [1:0] dir_i,
  input  logic       trig_i,
  output logic       edge_hit_o,
  output logic       latched_o,
  output logic       run_o
);
  trig_dir_e dir;
  logic      prev_q;
  logic      latch_q;
  logic      run_q;
  logic      run_d;
  logic      lvl_ok;

  assign dir        = trig_dir_e'(dir_i);
  assign edge_hit_o = arm_i && edge_qualifies(dir, prev_q, trig_i);
  assign lvl_ok     = level_qualifies(dir, trig_i);

  always_comb begin
    if (!arm_i)          run_d = 1'b0;
    else if (!hw_mode_i) run_d = 1'b1;
    else if (lvl_type_i) run_d = lvl_ok;
    else                 run_d = latch_q | edge_hit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      prev_q <= trig_i;
      if (!arm_i)          latch_q <= 1'b0;
      else if (edge_hit_o) latch_q <= 1'b1;
      run_q <= run_d;
    end
  end

  assign latched_o = latch_q;
  assign run_o     = run_q;

  // R2: software mode runs on the edge after arm is seen
  p_sw_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !hw_mode_i) |=> run_o);
  // R4: a qualifying edge in edge type latches run on
  p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode_i && !lvl_type_i && edge_hit_o) |=> (run_o && latched_o));
  // R6: level high type holds off while trigger is low
  p_level_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && hw_mode_i && lvl_type_i && dir_i == 2'b01 && !trig_i) |=> !run_o);
  // R10: de-arm clears latch
  p_disarm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !latched_o);
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       hw_mode_i,
  input  logic       src_ana_i,
  input  logic       lvl_type_i,
  input  logic [1:0] dir_i,
  input  logic       dig_trig_i,
  input  logic       cmp_hi_i,
  input  logic       cmp_lo_i,
  output logic       run_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn_in;
  logic             dig_s;
  logic             hi_s;
  logic             lo_s;
  logic             ana_state;
  logic             trig_sel;
  logic             edge_hit;
  logic             latched;

  assign raw_in = {cmp_lo_i, cmp_hi_i, dig_trig_i};
  assign dig_s  = syn_in[0];
  assign hi_s   = syn_in[1];
  assign lo_s   = syn_in[2];

  acq_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  acq_hyst u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .above_hi_i (hi_s),
    .below_lo_i (lo_s),
    .state_o    (ana_state)
  );

  assign trig_sel = src_ana_i ? ana_state : dig_s;

  acq_trig_qual u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .hw_mode_i  (hw_mode_i),
    .lvl_type_i (lvl_type_i),
    .dir_i      (dir_i),
    .trig_i     (trig_sel),
    .edge_hit_o (edge_hit),
    .latched_o  (latched),
    .run_o      (run_o)
  );

  // R10: de-arm drops run after the next edge
  p_disarm_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !run_o);
  // R3: run can only rise in edge type through a qualifying edge or latch
  p_edge_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && hw_mode_i && !lvl_type_i && !edge_hit && !latched) |=> !run_o);
endmodule

// File: tb/sim_acq_trig_ctrl.sv
`timescale 1ns/1ps
module sim_acq_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0, hw = 1'b0, src = 1'b0, lvl = 1'b0;
  logic [1:0] dir = 2'b00;
  logic       dig = 1'b0, hi = 1'b0, lo = 1'b0;
  logic       run;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  acq_trig_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .hw_mode_i(hw), .src_ana_i(src),
    .lvl_type_i(lvl), .dir_i(dir), .dig_trig_i(dig), .cmp_hi_i(hi),
    .cmp_lo_i(lo), .run_o(run)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (run !== exp) begin
      n_fail++;
      $display("FAIL %s: run_o=%b expected %b at %0t", req, run, exp, $time);
    end
  endtask

  task automatic setup(input logic h, input logic s, input logic l, input logic [1:0] d);
    arm = 1'b0; hw = h; src = s; lvl = l; dir = d;
    tick(6);
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b0);
  endtask

  task automatic t_soft;
    setup(1'b0, 1'b0, 1'b0, 2'b01);
    arm = 1'b1; tick(1);
    chk("R2 software start", 1'b1);
    dig = ~dig; tick(5);
    chk("R2 software ignores trigger", 1'b1);
    arm = 1'b0; tick(1);
    chk("R10 de-arm drop", 1'b0);
  endtask

  task automatic t_edge_rise;
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 2'b01);
    arm = 1'b1; tick(4);
    chk("R3 idle armed", 1'b0);
    dig = 1'b1; tick(2);
    chk("R9 digital not yet", 1'b0);
    tick(1);
    chk("R9 R3 rising start", 1'b1);
    dig = 1'b0; tick(5);
    chk("R4 later change ignored", 1'b1);
    arm = 1'b0; tick(1);
    chk("R10 drop", 1'b0);
    arm = 1'b1; tick(5);
    chk("R10 latch cleared on rearm", 1'b0);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_edge_fall;
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 2'b00);
    arm = 1'b1; tick(2);
    dig = 1'b1; tick(5);
    chk("R3 wrong polarity", 1'b0);
    dig = 1'b0; tick(5);
    chk("R3 falling start", 1'b1);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_pre_arm;
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 2'b01);
    dig = 1'b1; tick(5);
    arm = 1'b1; tick(5);
    chk("R5 pre-arm edge ignored", 1'b0);
    dig = 1'b0; tick(5);
    chk("R5 falling after arm ignored", 1'b0);
    dig = 1'b1; tick(5);
    chk("R5 fresh rise starts", 1'b1);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_either;
    dig = 1'b1;
    setup(1'b1, 1'b0, 1'b0, 2'b10);
    arm = 1'b1; tick(5);
    chk("R3 either idle", 1'b0);
    dig = 1'b0; tick(5);
    chk("R3 either on falling", 1'b1);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_level;
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b1, 2'b01);
    arm = 1'b1; tick(5);
    chk("R6 high level absent", 1'b0);
    dig = 1'b1; tick(5);
    chk("R6 high level run", 1'b1);
    dig = 1'b0; tick(5);
    chk("R6 pause", 1'b0);
    dig = 1'b1; tick(5);
    chk("R6 resume", 1'b1);
    arm = 1'b0; tick(1);
    dir = 2'b00; arm = 1'b1; tick(5);
    chk("R6 low level blocked", 1'b0);
    dig = 1'b0; tick(5);
    chk("R6 low level run", 1'b1);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_level_any;
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b1, 2'b11);
    arm = 1'b1; tick(1);
    chk("R7 either level like software", 1'b1);
    dig = 1'b1; tick(5);
    chk("R7 still running", 1'b1);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_analog;
    hi = 1'b0; lo = 1'b1;
    setup(1'b1, 1'b1, 1'b1, 2'b01);
    arm = 1'b1; tick(5);
    chk("R8 below low", 1'b0);
    lo = 1'b0; tick(5);
    chk("R8 band holds low", 1'b0);
    hi = 1'b1; tick(3);
    chk("R9 analog not yet", 1'b0);
    tick(1);
    chk("R9 R8 above high", 1'b1);
    hi = 1'b0; tick(5);
    chk("R8 band holds high", 1'b1);
    lo = 1'b1; tick(5);
    chk("R8 below low pauses", 1'b0);
    arm = 1'b0; tick(1);
  endtask

  task automatic t_src_ignore;
    hi = 1'b0; lo = 1'b1; dig = 1'b0;
    setup(1'b1, 1'b1, 1'b0, 2'b01);
    arm = 1'b1; tick(3);
    dig = 1'b1; tick(5);
    chk("R11 digital ignored in analog", 1'b0);
    dig = 1'b0;
    setup(1'b1, 1'b0, 1'b0, 2'b01);
    arm = 1'b1; tick(3);
    lo = 1'b0; hi = 1'b1; tick(6);
    chk("R11 analog ignored in digital", 1'b0);
    arm = 1'b0; tick(1);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_soft();
    t_edge_rise();
    t_edge_fall();
    t_pre_arm();
    t_either();
    t_level();
    t_level_any();
    t_analog();
    t_src_ignore();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run_o=%b expected completion", run);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule